// File: doc/BRIEF.md
# E1 Receive Frame Alignment Detector

This block takes a serial E1 receive stream, one bit per clock on the recovered bit clock, and finds where each 256-bit frame starts. It moves an eight-bit window along the stream until the seven low bits of time slot 0 read `0011011`. It then confirms that position twice. One frame later, the second bit of time slot 0 must be 1. Two frames later, the seven-bit alignment word must appear again. Only then does it declare alignment. While aligned it reports where the last received bit sits in the frame, as a slot index and a bit index. It also captures the spare bits carried in time slot 0.

A frame sync error flag is high whenever the block is not aligned. The transmit side of the line interface uses this flag as its request to send a remote alarm. The block drops alignment when the alignment word is bad three times in a row. It then searches again. A candidate that fails confirmation does not block the search. That phase is skipped for a while, so the search moves on to the other bit positions before it tries the same phase again.

Top module: `e1_frame_align`

## Requirements
- R1: Sync reset (`rst_n` low) gives `in_frame`=0, `fserr`=1, `slot_idx`=0, `bit_idx`=0 and clears `intl_bit`, `natl_bits` and `far_alarm`.
- R2: In search, a bit whose seven most recent bits (itself included, oldest first) read `0011011` becomes a candidate. The bit received before them is not compared. The position counter is loaded so that this bit reads `slot_idx`=0, `bit_idx`=7.
- R3: Exactly one frame after the candidate, the second received bit of time slot 0 (`bit_idx`=1) must be 1. If it is 0, the candidate fails and the block returns to search.
- R4: Exactly two frames after the candidate, the alignment word must end again at `bit_idx`=7 of slot 0. `in_frame` rises on the clock edge that takes in that last bit. A mismatch fails the candidate.
- R5: After a failed candidate, a match at the failed phase (`bit_idx`=7 of slot 0 on the running counter) is ignored for the next MASK_HITS (2) times that phase comes round. Matches at any other phase are accepted.
- R6: `slot_idx`/`bit_idx` give the frame position of the most recently received bit. Time slots go out most significant bit first, so `bit_idx`=0 is bit 7 of the octet. The position advances by one per clock and wraps from the last bit of the last slot to 0.
- R7: While aligned, LOSS_WORDS (3) consecutive alignment frames with a wrong word clear `in_frame` on the edge that takes in the third bad word's last bit. A good word in between restarts the count.
- R8: While aligned, bit 7 of time slot 0 is captured into `intl_bit` in every frame. In the frames between alignment words, bits 4..0 are captured into `natl_bits` and bit 5 into `far_alarm`. Out of alignment, none of these outputs change.
- R9: `fserr` is the complement of `in_frame`: it rises on loss and falls on lock, and it serves as the remote alarm request.
- R10: After a loss, the search resumes at once on the running stream, and alignment is regained through the same three steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received serial data bit |
| in_frame | output | 1 | Alignment confirmed |
| fserr | output | 1 | Frame sync error, remote alarm request |
| slot_idx | output | $clog2(NUM_SLOTS) | Time slot of the last received bit |
| bit_idx | output | 3 | Bit position within the slot (0 = first, octet MSB) |
| intl_bit | output | 1 | Captured bit 7 of time slot 0 |
| natl_bits | output | 5 | Captured bits 4..0 of the non-alignment word |
| far_alarm | output | 1 | Captured bit 5 of the non-alignment word |

## Verification
The bench builds the block with NUM_SLOTS=8, which gives 64-bit frames. LOSS_WORDS and MASK_HITS keep their defaults of 3 and 2. The short frames keep the alignment rules and the slot 0 layout unchanged, but they bring long multi-frame sequences within a few thousand clocks. These include a fake candidate that survives the first check, a masked repeat of the failed phase, the three-bad-word loss with a good word in between, and relock after loss. Fill octets of all ones keep accidental matches out of the stream, so every lock edge can be predicted exactly.

// File: rtl/e1fa_pkg.sv
// Package: shared types and constants for the E1 frame alignment detector.
// Assumes octets are sent most significant bit first.
package e1fa_pkg;

    // Alignment search and confirmation states
    typedef enum logic [1:0] {
        ST_SEARCH   = 2'd0,
        ST_CHK_NFAS = 2'd1,
        ST_CHK_FAS  = 2'd2,
        ST_SYNC     = 2'd3
    } align_state_e;

    // Seven-bit alignment word carried in bits 6..0 of time slot 0
    localparam logic [6:0] FAW_PATTERN = 7'b0011011;

    // Octet width of one time slot
    localparam int SLOT_BITS = 8;

endpackage

// File: rtl/e1fa_window.sv
// Module: e1fa_window
// Holds the last WIN_BITS received bits. It also presents the window as it
// will look once the current input bit is taken in, so the control logic can
// act on a match in the same clock edge. Assumes one new bit per clock.
module e1fa_window #(
    parameter int WIN_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_bit_i,
    output logic [WIN_BITS-1:0] win_next_o
);

    logic [WIN_BITS-1:0] sh_q;

    // Oldest bit at the top, the bit being taken in at bit 0
    assign win_next_o = {sh_q[WIN_BITS-2:0], rx_bit_i};

    // Shift one bit per clock; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= win_next_o;
    end

endmodule

// File: rtl/e1fa_pos_counter.sv
// Module: e1fa_pos_counter
// Frame bit position counter plus a frame parity flag (0 = alignment frame,
// 1 = non-alignment frame). pos_q is the position of the last received bit.
// pos_nxt_o/odd_nxt_o give the position of the bit now being taken in.
// A load places the current bit at LOAD_POS of an alignment frame.
module e1fa_pos_counter #(
    parameter int FRAME_BITS = 256,
    parameter int LOAD_POS   = 7,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_nxt_o,
    output logic             odd_nxt_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] LD_POS   = POS_W'(LOAD_POS);

    logic odd_q;

    // Next position with wrap at the end of the frame; parity flips on wrap
    always_comb begin
        pos_nxt_o = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        odd_nxt_o = (pos_q == LAST_POS) ? ~odd_q : odd_q;
    end

    // Advance every clock, or snap to the candidate position on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            odd_q <= 1'b0;
        end else if (load_i) begin
            pos_q <= LD_POS;
            odd_q <= 1'b0;
        end else begin
            pos_q <= pos_nxt_o;
            odd_q <= odd_nxt_o;
        end
    end

    // R6: position steps by one per clock when not loaded
    a_r6_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && pos_q != LAST_POS) |=> (pos_q == $past(pos_q) + 1'b1));

    // R6: wrap from the last bit goes to zero
    a_r6_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && pos_q == LAST_POS) |=> (pos_q == '0));

endmodule

// File: rtl/e1fa_ctrl.sv
// Module: e1fa_ctrl
// Alignment state machine: search, non-alignment bit check, alignment word
// confirmation and in-frame loss counting. It also captures the spare bits
// of time slot 0 and masks a failed candidate phase. Assumes win_next_i and
// the position inputs describe the bit being taken in on this clock edge.
module e1fa_ctrl
    import e1fa_pkg::*;
#(
    parameter int POS_W      = 8,
    parameter int LOSS_WORDS = 3,
    parameter int MASK_HITS  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOT_BITS-1:0] win_next_i,
    input  logic [POS_W-1:0]     pos_nxt_i,
    input  logic                 odd_nxt_i,
    output logic                 load_o,
    output logic                 in_frame_o,
    output logic                 fserr_o,
    output logic                 intl_o,
    output logic [4:0]           natl_o,
    output logic                 far_alarm_o
);

    localparam int BAD_W  = $clog2(LOSS_WORDS + 1);
    localparam int MASK_W = $clog2(MASK_HITS + 1);
    localparam logic [POS_W-1:0]  FAS_POS  = POS_W'(SLOT_BITS - 1);
    localparam logic [POS_W-1:0]  NFAS_POS = POS_W'(1);
    localparam logic [BAD_W-1:0]  BAD_LAST = BAD_W'(LOSS_WORDS - 1);
    localparam logic [MASK_W-1:0] MASK_SET = MASK_W'(MASK_HITS);

    align_state_e      state_q, state_d;
    logic [BAD_W-1:0]  bad_q;
    logic [MASK_W-1:0] mask_q;
    logic              in_frame_q, fserr_q, intl_q, far_q;
    logic [4:0]        natl_q;

    logic fas_hit, at_phase, at_fas_slot, at_nfas_bit, masked;
    logic fail, lock, lose;

    // Decode the incoming bit's position and the window contents
    always_comb begin
        fas_hit     = (win_next_i[6:0] == FAW_PATTERN);
        at_phase    = (pos_nxt_i == FAS_POS);
        at_fas_slot = at_phase && !odd_nxt_i;
        at_nfas_bit = (pos_nxt_i == NFAS_POS) && odd_nxt_i;
        masked      = (mask_q != '0) && at_phase;
    end

    // Next state and the lock, loss and failure events
    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        fail    = 1'b0;
        lock    = 1'b0;
        lose    = 1'b0;
        case (state_q)
            ST_SEARCH: begin
                if (fas_hit && !masked) begin
                    load_o  = 1'b1;
                    state_d = ST_CHK_NFAS;
                end
            end
            ST_CHK_NFAS: begin
                if (at_nfas_bit) begin
                    if (win_next_i[0]) begin
                        state_d = ST_CHK_FAS;
                    end else begin
                        fail    = 1'b1;
                        state_d = ST_SEARCH;
                    end
                end
            end
            ST_CHK_FAS: begin
                if (at_fas_slot) begin
                    if (fas_hit) begin
                        lock    = 1'b1;
                        state_d = ST_SYNC;
                    end else begin
                        fail    = 1'b1;
                        state_d = ST_SEARCH;
                    end
                end
            end
            ST_SYNC: begin
                if (at_fas_slot && !fas_hit && bad_q == BAD_LAST) begin
                    lose    = 1'b1;
                    state_d = ST_SEARCH;
                end
            end
            default: state_d = ST_SEARCH;
        endcase
    end

    // State register with the in-frame and sync error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_SEARCH;
            in_frame_q <= 1'b0;
            fserr_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            if (lock) begin
                in_frame_q <= 1'b1;
                fserr_q    <= 1'b0;
            end else if (lose) begin
                in_frame_q <= 1'b0;
                fserr_q    <= 1'b1;
            end
        end
    end

    // Count consecutive bad alignment words while in frame
    always_ff @(posedge clk) begin
        if (!rst_n || lock) begin
            bad_q <= '0;
        end else if (state_q == ST_SYNC && at_fas_slot) begin
            bad_q <= fas_hit ? '0 : bad_q + 1'b1;
        end
    end

    // Mask the failed candidate phase for MASK_HITS passes
    always_ff @(posedge clk) begin
        if (!rst_n || load_o) begin
            mask_q <= '0;
        end else if (fail) begin
            mask_q <= MASK_SET;
        end else if (state_q == ST_SEARCH && masked) begin
            mask_q <= mask_q - 1'b1;
        end
    end

    // Capture the international, national and far-end alarm bits in frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intl_q <= 1'b0;
            natl_q <= '0;
            far_q  <= 1'b0;
        end else if (state_q == ST_SYNC && at_phase) begin
            intl_q <= win_next_i[SLOT_BITS-1];
            if (odd_nxt_i) begin
                natl_q <= win_next_i[4:0];
                far_q  <= win_next_i[5];
            end
        end
    end

    assign in_frame_o  = in_frame_q;
    assign fserr_o     = fserr_q;
    assign intl_o      = intl_q;
    assign natl_o      = natl_q;
    assign far_alarm_o = far_q;

    // R4: in_frame only rises on a good alignment word at the expected slot
    a_r4_lock_on_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame_q) |-> $past(fas_hit && at_fas_slot));

    // R7: in_frame only falls on a bad alignment word at the expected slot
    a_r7_drop_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame_q) |-> $past(at_fas_slot && !fas_hit));

    // R9: error flag is always the complement of in_frame
    a_r9_fserr_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        fserr_q != in_frame_q);

    // R3: a zero in the non-alignment check bit returns to search
    a_r3_nfas_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHK_NFAS && at_nfas_bit && !win_next_i[0])
        |=> state_q == ST_SEARCH);

    // R5: a masked phase never starts a candidate
    a_r5_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH && masked) |=> state_q == ST_SEARCH);

    // R8: captured bits hold while out of frame
    a_r8_hold_captures: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame_q |=> ($stable(natl_q) && $stable(far_q) && $stable(intl_q)));

endmodule

// File: rtl/e1_frame_align.sv
// Module: e1_frame_align (top)
// E1 receive frame alignment detector. It takes one serial bit per clock,
// finds and confirms the time slot 0 alignment, reports the frame position
// and captures the spare bits. Assumes a recovered bit clock and octets
// sent most significant bit first.
module e1_frame_align
    import e1fa_pkg::*;
#(
    parameter int NUM_SLOTS  = 32,
    parameter int LOSS_WORDS = 3,
    parameter int MASK_HITS  = 2,
    localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int BIT_W      = $clog2(SLOT_BITS),
    localparam int TS_W       = POS_W - BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    output logic             in_frame,
    output logic             fserr,
    output logic [TS_W-1:0]  slot_idx,
    output logic [BIT_W-1:0] bit_idx,
    output logic             intl_bit,
    output logic [4:0]       natl_bits,
    output logic             far_alarm
);

    logic [SLOT_BITS-1:0] win_next;
    logic [POS_W-1:0]     pos_q, pos_nxt;
    logic                 odd_nxt;
    logic                 load;

    e1fa_window #(
        .WIN_BITS (SLOT_BITS)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit_i   (rx_bit),
        .win_next_o (win_next)
    );

    e1fa_pos_counter #(
        .FRAME_BITS (FRAME_BITS),
        .LOAD_POS   (SLOT_BITS - 1)
    ) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .pos_q     (pos_q),
        .pos_nxt_o (pos_nxt),
        .odd_nxt_o (odd_nxt)
    );

    e1fa_ctrl #(
        .POS_W      (POS_W),
        .LOSS_WORDS (LOSS_WORDS),
        .MASK_HITS  (MASK_HITS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_next_i  (win_next),
        .pos_nxt_i   (pos_nxt),
        .odd_nxt_i   (odd_nxt),
        .load_o      (load),
        .in_frame_o  (in_frame),
        .fserr_o     (fserr),
        .intl_o      (intl_bit),
        .natl_o      (natl_bits),
        .far_alarm_o (far_alarm)
    );

    // Split the frame position into slot and bit-in-slot
    assign slot_idx = pos_q[POS_W-1:BIT_W];
    assign bit_idx  = pos_q[BIT_W-1:0];

endmodule

// File: tb/e1_frame_align_tb.sv
`timescale 1ns/1ps
module e1_frame_align_tb;

    localparam int NS = 8;
    localparam int FB = NS * 8;
    localparam int TW = $clog2(NS);

    // Table: {intl bit of the alignment frame, non-alignment octet}
    localparam logic [8:0] VEC [6] = '{
        {1'b1, 8'hC0}, {1'b0, 8'h7F}, {1'b1, 8'hE5},
        {1'b0, 8'h4A}, {1'b1, 8'hDF}, {1'b0, 8'h55}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic          in_frame, fserr, intl_bit, far_alarm;
    logic [TW-1:0] slot_idx;
    logic [2:0]    bit_idx;
    logic [4:0]    natl_bits;
    int            checks = 0;
    int            errors = 0;

    always #2.5 clk = ~clk;

    e1_frame_align #(.NUM_SLOTS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx),
        .in_frame(in_frame), .fserr(fserr),
        .slot_idx(slot_idx), .bit_idx(bit_idx),
        .intl_bit(intl_bit), .natl_bits(natl_bits), .far_alarm(far_alarm)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one bit; it is taken in at the next rising edge
    task automatic send_bit(input logic b);
        rx = b;
        @(negedge clk);
    endtask

    // One frame: slot 0, slot 1, all other slots all ones
    task automatic send_frame(input logic [7:0] ts0, input logic [7:0] ts1);
        for (int i = 0; i < FB; i++) begin
            if (i < 8)       send_bit(ts0[7 - i]);
            else if (i < 16) send_bit(ts1[7 - (i - 8)]);
            else             send_bit(1'b1);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 in_frame", in_frame, 0);
        check("R1 fserr", fserr, 1);
        check("R1 slot_idx", slot_idx, 0);
        check("R1 bit_idx", bit_idx, 0);
        check("R1 captures", {intl_bit, far_alarm, natl_bits}, 0);

        // Clean start: the intl bit of 1 in frame 0 must not block the match (R2)
        send_frame(8'h9B, 8'hFF);
        send_frame(8'hFF, 8'hFF);
        check("R3 not locked after one frame", in_frame, 0);
        send_frame(8'h1B, 8'hFF);
        check("R4 locked after confirmation", in_frame, 1);
        check("R9 fserr cleared", fserr, 0);
        check("R2 slot at frame end", slot_idx, NS - 1);
        check("R6 bit at frame end", bit_idx, 7);
        send_bit(1'b1);
        check("R6 wrap slot", slot_idx, 0);
        check("R6 wrap bit", bit_idx, 0);
        for (int i = 1; i < FB; i++) send_bit(i < 8 ? VEC[0][7 - i] : 1'b1);
        check("R8 natl v0", natl_bits, VEC[0][4:0]);
        check("R8 far v0", far_alarm, VEC[0][5]);
        send_frame({VEC[0][8], 7'h1B}, 8'hFF);
        check("R8 intl v0 fas", intl_bit, VEC[0][8]);

        // Table walk over the spare bits (R8)
        for (int v = 1; v < 6; v++) begin
            send_frame(VEC[v][7:0], 8'hFF);
            check("R8 natl", natl_bits, VEC[v][4:0]);
            check("R8 far_alarm", far_alarm, VEC[v][5]);
            check("R8 intl nfas", intl_bit, VEC[v][7]);
            send_frame({VEC[v][8], 7'h1B}, 8'hFF);
            check("R8 intl fas", intl_bit, VEC[v][8]);
            check("R8 still in frame", in_frame, 1);
        end

        // Loss counting (R7)
        send_frame(8'hFF, 8'hFF); send_frame(8'h00, 8'hFF);
        send_frame(8'hFF, 8'hFF); send_frame(8'h00, 8'hFF);
        send_frame(8'hFF, 8'hFF); send_frame(8'h1B, 8'hFF);
        check("R7 good word restarts count", in_frame, 1);
        send_frame(8'hFF, 8'hFF); send_frame(8'h00, 8'hFF);
        send_frame(8'hFF, 8'hFF); send_frame(8'h00, 8'hFF);
        check("R7 two bad words keep frame", in_frame, 1);
        send_frame(8'hFF, 8'hFF); send_frame(8'h00, 8'hFF);
        check("R7 third bad word drops", in_frame, 0);
        check("R9 fserr on loss", fserr, 1);
        send_frame(8'hC3, 8'hFF);
        check("R8 natl held out of frame", natl_bits, 5'h1F);
        check("R8 far held out of frame", far_alarm, 1);

        // Relock after loss (R10)
        send_frame(8'h1B, 8'hFF);
        send_frame(8'hFF, 8'hFF);
        check("R10 not yet relocked", in_frame, 0);
        send_frame(8'h1B, 8'hFF);
        check("R10 relocked", in_frame, 1);

        // Failed non-alignment check, then a masked phase (R3, R5)
        do_reset();
        send_frame(8'h1B, 8'hFF);
        send_frame(8'h80, 8'hFF);
        send_frame(8'h1B, 8'hFF);
        send_frame(8'hFF, 8'hFF);
        send_frame(8'h1B, 8'hFF);
        check("R5 failed phase masked twice", in_frame, 0);
        send_frame(8'hFF, 8'hFF);
        check("R3 no lock before confirm", in_frame, 0);
        send_frame(8'h1B, 8'hFF);
        check("R3 lock after retry", in_frame, 1);

        // Fake candidate in slot 1 that fails at the word check (R5, R2)
        do_reset();
        send_frame(8'hFF, 8'h1B);
        send_frame(8'hFF, 8'hFF);
        send_frame(8'hFF, 8'hFF);
        send_frame(8'hFF, 8'h1B);
        send_frame(8'hFF, 8'hFF);
        send_frame(8'h1B, 8'hFF);
        send_frame(8'hFF, 8'hFF);
        check("R5 no lock before true confirm", in_frame, 0);
        send_frame(8'h1B, 8'hFF);
        check("R5 locked on true phase", in_frame, 1);
        check("R2 slot aligned to true frame", slot_idx, NS - 1);
        check("R2 bit aligned to true frame", bit_idx, 7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule